// File: doc/BRIEF.md
# Cache Write-Policy Controller

This block is the access-decision stage of a small set-associative data cache. Each cycle it may take one request (address, read or write, atomic flag, global or local space) and, in the same cycle, answers HIT, MISS or RESERVATION_FAIL. Lines are looked up in an internal tag/state array with least-recently-used replacement. The write-hit policy and the write-miss policy are static configuration inputs, held steady while requests are in flight. Accepted requests update line state and LRU order at the next clock edge. Any traffic for the lower level (write-through data, line fills and dirty-victim write-backs) is pushed into a bounded miss queue. A small table of outstanding fills lets write-allocate misses merge into a fill that is already pending.

A request is only accepted when the worst case it could need fits now. That covers miss-queue slots, and for write-allocate also a fill-tracking entry. Otherwise the answer is RESERVATION_FAIL, nothing changes, and the requester must present the request again later. The free-slot count uses the queue occupancy at the start of the cycle, so a pop in the same cycle gives no credit. The miss queue leaves through a valid/ready port. An entry is presented while `mq_valid` is high and is held unchanged until `mq_ready` is seen high at a clock edge. Data storage and the lower memory are not part of the block.

Address layout with the default parameters: bits [3:0] are the byte offset in a 16-byte line, bits [5:4] select one of 4 sets (2 ways each), and bits [15:6] are the tag. The miss queue holds 8 entries. The fill table holds 2 blocks, and each block accepts up to 2 merges.

Top module: `cache_wpol_ctrl`

## Requirements
- R1: After reset the miss queue is empty (`mq_valid` low), every line is invalid so the first access to any block misses, and with `req_valid` low `rsp_code` reads 3 (idle). Response codes while `req_valid` is high: 0 = HIT, 1 = MISS, 2 = RESERVATION_FAIL.
- R2: When `probe_rsv_fail` is high with a request, the answer is RESERVATION_FAIL for every policy and nothing changes.
- R3: Write-back write hit (`cfg_wr_hit` = 0): answers HIT, touches LRU, marks the line modified, pushes nothing. A later eviction of that line pushes a write-back.
- R4: Write-through write hit (`cfg_wr_hit` = 1): needs one free slot, pushes one WRITE entry carrying the request address, answers HIT, and leaves the line state as it was.
- R5: Write-evict write hit (`cfg_wr_hit` = 2): needs one free slot, pushes one WRITE entry, invalidates the line, answers HIT. The next read of that block misses.
- R6: Mixed policy (`cfg_wr_hit` = 3): a hit by a global write (`req_global` = 1) behaves as R5, and a hit by a local write behaves as R3.
- R7: Write-allocate write miss (`cfg_wr_alloc` = 1): needs three free slots and a fill-table entry it can merge into or allocate. It pushes WRITE (request address), then FILL (block address) unless merged, then WRITE-BACK (victim block address) if the victim was modified. It installs the line clean, answers MISS, and leaves a later read of that block hitting.
- R8: No-allocate write miss (`cfg_wr_alloc` = 0): needs one free slot, pushes only WRITE, answers MISS, and installs nothing.
- R9: Read hit answers HIT and touches LRU. An atomic read hit also marks the line modified.
- R10: Read miss needs two free slots. It pushes FILL (block address), then WRITE-BACK of the victim if the victim was modified, installs the line clean and answers MISS.
- R11: A rejected request pushes nothing and changes no line state or LRU order.
- R12: The victim is the lowest-numbered invalid way, or otherwise the least recently used way.
- R13: The miss queue is first-in first-out. Entry kinds are 0 = WRITE, 1 = FILL, 2 = WRITE-BACK. An entry is held steady while not accepted, the queue never exceeds its depth, and free slots are counted without credit for a same-cycle pop.
- R14: A fill-table entry is freed when a FILL for its block leaves the queue. A write-allocate miss to a block with a pending fill merges (no new FILL) up to the merge limit. With no entry to merge into and none free, the miss is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_hit | input | 2 | Write-hit policy: 0 back, 1 through, 2 evict, 3 mixed |
| cfg_wr_alloc | input | 1 | 1 = allocate on write miss |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Atomic read |
| req_global | input | 1 | 1 = global space, 0 = local |
| probe_rsv_fail | input | 1 | Lookup could not reserve resources this cycle |
| rsp_code | output | 2 | 0 HIT, 1 MISS, 2 RESERVATION_FAIL, 3 idle |
| mq_valid | output | 1 | Miss-queue head valid |
| mq_ready | input | 1 | Consumer takes the head |
| mq_kind | output | 2 | Head kind: 0 WRITE, 1 FILL, 2 WRITE-BACK |
| mq_addr | output | AW | Head address |

## Verification
The checker watches every cycle for the following: forced and capacity rejections push nothing, write-back hits stay silent, accepted no-allocate misses push exactly one entry, accepted read misses push at least one entry, the queue head stays steady under back-pressure, and occupancy stays within the queue depth. Some behaviour only shows up over several requests, so only the bench scenarios can show it. That includes line state left behind by each policy, which later shows as a hit, a miss or a write-back on eviction. It also includes LRU victim choice, FIFO order of the pushed entries, capacity limits at exact boundaries, and fill merging and release in the fill table.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {RSP_HIT = 2'd0, RSP_MISS = 2'd1, RSP_RFAIL = 2'd2, RSP_IDLE = 2'd3} rsp_e;
  typedef enum logic [1:0] {Q_WRITE = 2'd0, Q_FILL = 2'd1, Q_WBACK = 2'd2} qkind_e;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_VAL = 2'd1, LN_MOD = 2'd2} lstate_e;
  typedef enum logic [1:0] {WH_BACK = 2'd0, WH_THRU = 2'd1, WH_EVICT = 2'd2, WH_MIXED = 2'd3} whpol_e;
endpackage

// File: rtl/wpc_tags.sv
module wpc_tags
  import wpc_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int SET_W = 2,
  parameter int WAYS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BLK_W-1:0]     lk_blk,
  output logic                 hit,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] hit_way,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] vic_way,
  output logic                 vic_dirty,
  output logic [BLK_W-1:0]     vic_blk,
  input  logic                 upd_en,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] upd_way,
  input  logic                 upd_touch,
  input  logic                 upd_set_state,
  input  lstate_e              upd_state,
  input  logic                 upd_set_tag
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = BLK_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  lstate_e          st_q  [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [WAY_W-1:0] lru_way, inv_way;
  logic             any_inv;

  assign set_idx = lk_blk[SET_W-1:0];
  assign tag_in  = lk_blk[BLK_W-1:SET_W];

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st_q[set_idx][w] != LN_INV && tag_q[set_idx][w] == tag_in) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // Victim: lowest invalid way, else the way with the oldest age
  always_comb begin
    lru_way = '0;
    inv_way = '0;
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      if (st_q[set_idx][w] == LN_INV) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
    end
    vic_way   = any_inv ? inv_way : lru_way;
    vic_dirty = (st_q[set_idx][vic_way] == LN_MOD);
    vic_blk   = {tag_q[set_idx][vic_way], set_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= LN_INV;
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (upd_en) begin
      if (upd_touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way) age_q[set_idx][w] <= '0;
          else if (age_q[set_idx][w] < age_q[set_idx][upd_way])
            age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
        end
      end
      if (upd_set_state) st_q[set_idx][upd_way] <= upd_state;
      if (upd_set_tag)   tag_q[set_idx][upd_way] <= tag_in;
    end
  end
endmodule

// File: rtl/wpc_mq.sv
module wpc_mq #(
  parameter int DW    = 18,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          push_n,
  input  logic [2:0][DW-1:0]  push_d,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic [CNT_W-1:0]    count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt_q  <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (2'(k) < push_n) mem[wr_ptr + PTR_W'(k)] <= push_d[k];
    end
  end
endmodule

// File: rtl/wpc_mshr.sv
module wpc_mshr #(
  parameter int BLK_W     = 12,
  parameter int N         = 2,
  parameter int MERGE_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] lk_blk,
  output logic             can_take,
  output logic             is_merge,
  input  logic             commit,
  input  logic             rel_en,
  input  logic [BLK_W-1:0] rel_blk
);
  localparam int MC_W  = $clog2(MERGE_MAX + 1);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             vld_q [N];
  logic [BLK_W-1:0] blk_q [N];
  logic [MC_W-1:0]  mc_q  [N];

  logic             match, any_free;
  logic [IDX_W-1:0] m_idx, f_idx;

  always_comb begin
    match = 1'b0;
    m_idx = '0;
    any_free = 1'b0;
    f_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      // an entry retiring this cycle cannot take a merge
      if (vld_q[i] && blk_q[i] == lk_blk && !(rel_en && rel_blk == blk_q[i])) begin
        match = 1'b1;
        m_idx = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        any_free = 1'b1;
        f_idx = IDX_W'(i);
      end
    end
    is_merge = match;
    can_take = match ? (mc_q[m_idx] < MC_W'(MERGE_MAX)) : any_free;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        vld_q[i] <= 1'b0;
        blk_q[i] <= '0;
        mc_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rel_en && vld_q[i] && blk_q[i] == rel_blk) vld_q[i] <= 1'b0;
      end
      if (commit) begin
        if (match) begin
          mc_q[m_idx] <= mc_q[m_idx] + 1'b1;
        end else begin
          vld_q[f_idx] <= 1'b1;
          blk_q[f_idx] <= lk_blk;
          mc_q[f_idx]  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cache_wpol_ctrl.sv
module cache_wpol_ctrl
  import wpc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int OFF_W     = 4,
  parameter int SET_W     = 2,
  parameter int WAYS      = 2,
  parameter int MQ_DEPTH  = 8,
  parameter int MSHR_N    = 2,
  parameter int MERGE_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_wr_hit,
  input  logic          cfg_wr_alloc,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_atomic,
  input  logic          req_global,
  input  logic          probe_rsv_fail,
  output logic [1:0]    rsp_code,
  output logic          mq_valid,
  input  logic          mq_ready,
  output logic [1:0]    mq_kind,
  output logic [AW-1:0] mq_addr
);
  localparam int BLK_W    = AW - OFF_W;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int MQ_CNT_W = $clog2(MQ_DEPTH + 1);
  localparam int QW       = AW + 2;

  logic [BLK_W-1:0]    req_blk;
  logic                tag_hit, vic_dirty;
  logic [WAY_W-1:0]    hit_way, vic_way;
  logic [BLK_W-1:0]    vic_blk;
  logic                upd_en, upd_touch, upd_set_state, upd_set_tag;
  logic [WAY_W-1:0]    upd_way;
  lstate_e             upd_state;
  logic [1:0]          push_n;
  logic [2:0][QW-1:0]  push_d;
  logic [QW-1:0]       mq_data;
  logic [MQ_CNT_W-1:0] mq_count, mq_free;
  logic                mshr_ok, mshr_merge, mshr_commit, fill_out;
  whpol_e              eff_pol;
  rsp_e                rsp;

  assign req_blk  = req_addr[AW-1:OFF_W];
  assign mq_free  = MQ_CNT_W'(MQ_DEPTH) - mq_count;
  assign mq_kind  = mq_data[QW-1:AW];
  assign mq_addr  = mq_data[AW-1:0];
  assign fill_out = mq_valid && mq_ready && (mq_kind == Q_FILL);
  assign rsp_code = rsp;

  wpc_tags #(.BLK_W(BLK_W), .SET_W(SET_W), .WAYS(WAYS)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_blk(req_blk),
    .hit(tag_hit), .hit_way(hit_way), .vic_way(vic_way),
    .vic_dirty(vic_dirty), .vic_blk(vic_blk),
    .upd_en(upd_en), .upd_way(upd_way), .upd_touch(upd_touch),
    .upd_set_state(upd_set_state), .upd_state(upd_state), .upd_set_tag(upd_set_tag)
  );

  wpc_mq #(.DW(QW), .DEPTH(MQ_DEPTH), .CNT_W(MQ_CNT_W)) u_mq (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_d(push_d),
    .out_valid(mq_valid), .out_ready(mq_ready), .out_data(mq_data), .count(mq_count)
  );

  wpc_mshr #(.BLK_W(BLK_W), .N(MSHR_N), .MERGE_MAX(MERGE_MAX)) u_mshr (
    .clk(clk), .rst_n(rst_n), .lk_blk(req_blk),
    .can_take(mshr_ok), .is_merge(mshr_merge), .commit(mshr_commit),
    .rel_en(fill_out), .rel_blk(mq_addr[AW-1:OFF_W])
  );

  always_comb begin
    eff_pol = whpol_e'(cfg_wr_hit);
    if (eff_pol == WH_MIXED) eff_pol = req_global ? WH_EVICT : WH_BACK;
  end

  always_comb begin
    rsp           = RSP_IDLE;
    push_n        = '0;
    push_d        = '0;
    upd_en        = 1'b0;
    upd_way       = hit_way;
    upd_touch     = 1'b0;
    upd_set_state = 1'b0;
    upd_state     = LN_VAL;
    upd_set_tag   = 1'b0;
    mshr_commit   = 1'b0;
    if (req_valid) begin
      if (probe_rsv_fail) begin
        rsp = RSP_RFAIL;
      end else if (req_write && tag_hit) begin
        case (eff_pol)
          WH_BACK: begin
            rsp           = RSP_HIT;
            upd_en        = 1'b1;
            upd_touch     = 1'b1;
            upd_set_state = 1'b1;
            upd_state     = LN_MOD;
          end
          WH_THRU: begin
            if (mq_free >= MQ_CNT_W'(1)) begin
              rsp       = RSP_HIT;
              push_n    = 2'd1;
              push_d[0] = {Q_WRITE, req_addr};
            end else rsp = RSP_RFAIL;
          end
          default: begin
            if (mq_free >= MQ_CNT_W'(1)) begin
              rsp           = RSP_HIT;
              push_n        = 2'd1;
              push_d[0]     = {Q_WRITE, req_addr};
              upd_en        = 1'b1;
              upd_set_state = 1'b1;
              upd_state     = LN_INV;
            end else rsp = RSP_RFAIL;
          end
        endcase
      end else if (req_write && cfg_wr_alloc) begin
        if (mq_free >= MQ_CNT_W'(3) && mshr_ok) begin
          rsp         = RSP_MISS;
          mshr_commit = 1'b1;
          push_d[0]   = {Q_WRITE, req_addr};
          push_n      = 2'd1;
          if (!mshr_merge) begin
            push_d[push_n] = {Q_FILL, req_blk, OFF_W'(0)};
            push_n         = push_n + 2'd1;
          end
          if (vic_dirty) begin
            push_d[push_n] = {Q_WBACK, vic_blk, OFF_W'(0)};
            push_n         = push_n + 2'd1;
          end
          upd_en        = 1'b1;
          upd_way       = vic_way;
          upd_touch     = 1'b1;
          upd_set_state = 1'b1;
          upd_state     = LN_VAL;
          upd_set_tag   = 1'b1;
        end else rsp = RSP_RFAIL;
      end else if (req_write) begin
        if (mq_free >= MQ_CNT_W'(1)) begin
          rsp       = RSP_MISS;
          push_n    = 2'd1;
          push_d[0] = {Q_WRITE, req_addr};
        end else rsp = RSP_RFAIL;
      end else if (tag_hit) begin
        rsp       = RSP_HIT;
        upd_en    = 1'b1;
        upd_touch = 1'b1;
        if (req_atomic) begin
          upd_set_state = 1'b1;
          upd_state     = LN_MOD;
        end
      end else begin
        if (mq_free >= MQ_CNT_W'(2)) begin
          rsp       = RSP_MISS;
          push_d[0] = {Q_FILL, req_blk, OFF_W'(0)};
          push_n    = 2'd1;
          if (vic_dirty) begin
            push_d[1] = {Q_WBACK, vic_blk, OFF_W'(0)};
            push_n    = 2'd2;
          end
          upd_en        = 1'b1;
          upd_way       = vic_way;
          upd_touch     = 1'b1;
          upd_set_state = 1'b1;
          upd_state     = LN_VAL;
          upd_set_tag   = 1'b1;
        end else rsp = RSP_RFAIL;
      end
    end
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_global,
  input logic [1:0]       cfg_wr_hit,
  input logic             cfg_wr_alloc,
  input logic             probe_rsv_fail,
  input logic [1:0]       rsp_code,
  input logic             tag_hit,
  input logic [1:0]       push_n,
  input logic [CNT_W-1:0] mq_count,
  input logic             mq_valid,
  input logic             mq_ready,
  input logic [1:0]       mq_kind,
  input logic [AW-1:0]    mq_addr
);
  a_r2_forced_reject: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && probe_rsv_fail |-> rsp_code == 2'd2);

  a_r11_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_code == 2'd2 |-> push_n == 2'd0);

  a_r3_wb_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && tag_hit && !probe_rsv_fail &&
    (cfg_wr_hit == 2'd0 || (cfg_wr_hit == 2'd3 && !req_global))
    |-> rsp_code == 2'd0 && push_n == 2'd0);

  a_r8_noalloc_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !tag_hit && !cfg_wr_alloc && rsp_code == 2'd1
    |-> push_n == 2'd1);

  a_r10_read_miss_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && rsp_code == 2'd1 |-> push_n != 2'd0);

  a_r13_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mq_valid && !mq_ready |=> mq_valid && $stable(mq_kind) && $stable(mq_addr));

  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    mq_count <= CNT_W'(DEPTH));
endmodule

bind cache_wpol_ctrl wpc_checker #(.AW(AW), .DEPTH(MQ_DEPTH), .CNT_W(MQ_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_global(req_global), .cfg_wr_hit(cfg_wr_hit), .cfg_wr_alloc(cfg_wr_alloc),
  .probe_rsv_fail(probe_rsv_fail), .rsp_code(rsp_code), .tag_hit(tag_hit),
  .push_n(push_n), .mq_count(mq_count), .mq_valid(mq_valid), .mq_ready(mq_ready),
  .mq_kind(mq_kind), .mq_addr(mq_addr)
);

// File: tb/sim_cache_wpol_ctrl.sv
module sim_cache_wpol_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int C_HIT = 0, C_MISS = 1, C_RFAIL = 2, C_IDLE = 3;
  localparam int K_WR = 0, K_FILL = 1, K_WB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_wr_hit = 2'd0;
  logic          cfg_wr_alloc = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_atomic = 1'b0;
  logic          req_global = 1'b0;
  logic          probe_rsv_fail = 1'b0;
  logic [1:0]    rsp_code;
  logic          mq_valid;
  logic          mq_ready = 1'b0;
  logic [1:0]    mq_kind;
  logic [AW-1:0] mq_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  cache_wpol_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_hit(cfg_wr_hit), .cfg_wr_alloc(cfg_wr_alloc),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_atomic(req_atomic), .req_global(req_global), .probe_rsv_fail(probe_rsv_fail),
    .rsp_code(rsp_code), .mq_valid(mq_valid), .mq_ready(mq_ready),
    .mq_kind(mq_kind), .mq_addr(mq_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic req(input bit w, input logic [AW-1:0] a, input bit atom, input bit glob,
                     input bit rf, input int exp, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    req_atomic = atom; req_global = glob; probe_rsv_fail = rf;
    #1 chk(int'(rsp_code) == exp, rq, int'(rsp_code), exp);
    @(posedge clk);
    #1 req_valid = 1'b0; probe_rsv_fail = 1'b0; req_atomic = 1'b0;
  endtask

  task automatic pop_exp(input int kind, input logic [AW-1:0] a, input string rq);
    @(negedge clk);
    chk(mq_valid && int'(mq_kind) == kind && mq_addr == a, rq,
        int'({mq_valid, mq_kind, mq_addr}), int'({1'b1, 2'(kind), a}));
    mq_ready = 1'b1;
    @(posedge clk);
    #1 mq_ready = 1'b0;
  endtask

  task automatic expect_empty(input string rq);
    @(negedge clk);
    chk(!mq_valid, rq, int'(mq_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    expect_empty("R1");
    @(negedge clk);
    chk(int'(rsp_code) == C_IDLE, "R1", int'(rsp_code), C_IDLE);
    req(0, 16'h0010, 0, 1, 0, C_MISS, "R1");
    pop_exp(K_FILL, 16'h0010, "R1");

    // Sweep of write-hit policies and access spaces (R3 R4 R5 R6)
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < 2; g++) begin
        int eff;
        string tg;
        cfg_wr_hit = 2'(p);
        cfg_wr_alloc = 1'b0;
        do_reset();
        eff = (p == 3) ? (g == 1 ? 2 : 0) : p;
        tg = (p == 3) ? "R6" : (eff == 0 ? "R3" : (eff == 1 ? "R4" : "R5"));
        req(0, 16'h0010, 0, 1, 0, C_MISS, "R10");
        pop_exp(K_FILL, 16'h0010, "R10");
        req(1, 16'h0014, 0, g[0], 0, C_HIT, tg);
        if (eff != 0) pop_exp(K_WR, 16'h0014, tg);
        expect_empty(tg);
        req(0, 16'h0010, 0, 1, 0, (eff == 2) ? C_MISS : C_HIT, tg);
        if (eff == 2) pop_exp(K_FILL, 16'h0010, tg);
        req(0, 16'h0110, 0, 1, 0, C_MISS, "R10");
        pop_exp(K_FILL, 16'h0110, "R10");
        req(0, 16'h0210, 0, 1, 0, C_MISS, tg);
        pop_exp(K_FILL, 16'h0210, tg);
        if (eff == 0) pop_exp(K_WB, 16'h0010, tg);
        expect_empty(tg);
      end
    end

    // R2: forced reservation failure installs nothing
    cfg_wr_hit = 2'd0; cfg_wr_alloc = 1'b0;
    do_reset();
    req(0, 16'h0030, 0, 1, 1, C_RFAIL, "R2");
    expect_empty("R2");
    req(0, 16'h0030, 0, 1, 0, C_MISS, "R2");
    pop_exp(K_FILL, 16'h0030, "R2");

    // R12: LRU victim
    do_reset();
    req(0, 16'h0010, 0, 1, 0, C_MISS, "R12");
    req(0, 16'h0110, 0, 1, 0, C_MISS, "R12");
    req(0, 16'h0010, 0, 1, 0, C_HIT, "R12");
    req(0, 16'h0210, 0, 1, 0, C_MISS, "R12");
    req(0, 16'h0010, 0, 1, 0, C_HIT, "R12");
    req(0, 16'h0110, 0, 1, 0, C_MISS, "R12");
    pop_exp(K_FILL, 16'h0010, "R12");
    pop_exp(K_FILL, 16'h0110, "R12");
    pop_exp(K_FILL, 16'h0210, "R12");
    pop_exp(K_FILL, 16'h0110, "R12");
    expect_empty("R12");

    // R9: atomic read hit dirties the line
    do_reset();
    req(0, 16'h0010, 0, 1, 0, C_MISS, "R9");
    req(0, 16'h0018, 1, 1, 0, C_HIT, "R9");
    req(0, 16'h0110, 0, 1, 0, C_MISS, "R9");
    req(0, 16'h0210, 0, 1, 0, C_MISS, "R9");
    pop_exp(K_FILL, 16'h0010, "R9");
    pop_exp(K_FILL, 16'h0110, "R9");
    pop_exp(K_FILL, 16'h0210, "R9");
    pop_exp(K_WB, 16'h0010, "R9");

    // R8: no-allocate write miss installs nothing
    do_reset();
    req(1, 16'h0054, 0, 1, 0, C_MISS, "R8");
    pop_exp(K_WR, 16'h0054, "R8");
    req(0, 16'h0050, 0, 1, 0, C_MISS, "R8");
    pop_exp(K_FILL, 16'h0050, "R8");

    // R11 R13: read miss capacity boundary and FIFO order
    do_reset();
    for (int i = 0; i < 7; i++) req(1, 16'h0100 + 16'(i * 16), 0, 1, 0, C_MISS, "R13");
    req(0, 16'h0300, 0, 1, 0, C_RFAIL, "R11");
    pop_exp(K_WR, 16'h0100, "R13");
    req(0, 16'h0300, 0, 1, 0, C_MISS, "R11");
    for (int i = 1; i < 7; i++) pop_exp(K_WR, 16'h0100 + 16'(i * 16), "R13");
    pop_exp(K_FILL, 16'h0300, "R11");
    expect_empty("R13");

    // R7: write-allocate needs three slots
    do_reset();
    for (int i = 0; i < 6; i++) req(1, 16'h0100 + 16'(i * 16), 0, 1, 0, C_MISS, "R7");
    cfg_wr_alloc = 1'b1;
    req(1, 16'h0404, 0, 1, 0, C_RFAIL, "R7");
    pop_exp(K_WR, 16'h0100, "R7");
    req(1, 16'h0404, 0, 1, 0, C_MISS, "R7");
    for (int i = 1; i < 6; i++) pop_exp(K_WR, 16'h0100 + 16'(i * 16), "R7");
    pop_exp(K_WR, 16'h0404, "R7");
    pop_exp(K_FILL, 16'h0400, "R7");
    req(0, 16'h0400, 0, 1, 0, C_HIT, "R7");

    // R7: write-allocate with dirty victim
    do_reset();
    req(0, 16'h0010, 0, 1, 0, C_MISS, "R7");
    pop_exp(K_FILL, 16'h0010, "R7");
    req(1, 16'h0010, 0, 1, 0, C_HIT, "R3");
    req(0, 16'h0110, 0, 1, 0, C_MISS, "R7");
    pop_exp(K_FILL, 16'h0110, "R7");
    req(1, 16'h0214, 0, 1, 0, C_MISS, "R7");
    pop_exp(K_WR, 16'h0214, "R7");
    pop_exp(K_FILL, 16'h0210, "R7");
    pop_exp(K_WB, 16'h0010, "R7");
    req(0, 16'h0210, 0, 1, 0, C_HIT, "R7");

    // R14: fill table full, then released by a dequeued fill
    do_reset();
    req(1, 16'h0000, 0, 1, 0, C_MISS, "R14");
    req(1, 16'h0010, 0, 1, 0, C_MISS, "R14");
    req(1, 16'h0020, 0, 1, 0, C_RFAIL, "R14");
    pop_exp(K_WR, 16'h0000, "R14");
    pop_exp(K_FILL, 16'h0000, "R14");
    req(1, 16'h0020, 0, 1, 0, C_MISS, "R14");
    pop_exp(K_WR, 16'h0010, "R14");
    pop_exp(K_FILL, 16'h0010, "R14");
    pop_exp(K_WR, 16'h0020, "R14");
    pop_exp(K_FILL, 16'h0020, "R14");
    expect_empty("R14");

    // R14: merge into a pending fill
    do_reset();
    req(1, 16'h0000, 0, 1, 0, C_MISS, "R14");
    req(0, 16'h0100, 0, 1, 0, C_MISS, "R14");
    req(0, 16'h0200, 0, 1, 0, C_MISS, "R14");
    req(1, 16'h0004, 0, 1, 0, C_MISS, "R14");
    pop_exp(K_WR, 16'h0000, "R14");
    pop_exp(K_FILL, 16'h0000, "R14");
    pop_exp(K_FILL, 16'h0100, "R14");
    pop_exp(K_FILL, 16'h0200, "R14");
    pop_exp(K_WR, 16'h0004, "R14");
    expect_empty("R14");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule